// File: doc/BRIEF.md
# Lockable Sticky Configuration Register Bank

This block holds a handful of software-visible configuration and status words whose fields differ in how they are written, reset and frozen. Software accesses it through a simple synchronous port: a write strobe with word address, write data and per-byte enables, and a read strobe whose data appears on the following clock. Hardware feeds it event pulses that set status bits, and per-bit update requests that overwrite volatile fields.

Field kinds:
- Plain read/write fields.
- Write-one-to-clear status bits.
- Volatile fields that hardware may overwrite at any time.
- Sticky fields.
- Key bits that make other fields read-only.
- A cascaded key that is itself frozen by an upstream key.
- A self-locking byte that freezes itself once it holds anything other than its reset value.

There are two synchronous reset inputs. The warm reset returns the non-sticky fields to their defaults and leaves the sticky ones alone. The cold reset returns every field to its default.

Word map (3-bit word address), with field positions as bits of the 32-bit data:

| Address | Word | Fields |
|---|---|---|
| 0 | Keys | bit0 upstream key, bit1 cascaded key |
| 1 | Config | [15:0] lockable field (default 0x00A5), [31:16] free field |
| 2 | Status | [7:0] sticky write-one-to-clear bits, [23:16] lockable sticky write-one-to-clear bits |
| 3 | Volatile | [7:0] volatile lockable bits, [23:16] volatile lockable sticky bits |
| 4 | Sticky | [15:0] sticky read/write field |
| 5 | Self-lock | [7:0] self-locking byte |

Unlisted bits read as zero. The default of every field except the config lockable field is zero.

Top module: `cfgbank`

## Requirements
- R1: A cold reset returns every field to its default, and reading it back gives zero for every word except Config, which reads 0x000000A5.
- R2: A write changes only the byte lanes whose enable bit is set; bit b of the data belongs to lane b/8.
- R3: In Status, writing 1 to a bit clears it and writing 0 leaves it unchanged. An event pulse sets its bit. When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: A warm reset leaves the sticky fields unchanged: Status bits, the Volatile bits [23:16] and the Sticky word. The same warm reset returns the keys, Config, the Volatile bits [7:0] and the self-lock byte to their defaults. A cold reset clears the sticky fields as well.
- R5: While the upstream key (Keys bit0) is 1, the bank ignores three kinds of software write: writes to the cascaded key, writes to both Volatile fields, and clearing writes to the Status bits [23:16]. The upstream key itself stays writable.
- R6: While the cascaded key (Keys bit1) is 1, software writes to Config [15:0] are ignored, and Config [31:16] stays writable. Clearing the cascaded key makes Config [15:0] writable again.
- R7: Each write to Keys evaluates the locks on the key values held before that write. Writing 0b11 with both keys clear therefore sets both keys.
- R8: A hardware update request on a Volatile bit loads the requested value, even while the bit is locked to software. It also wins over a software write to the same bit in the same cycle.
- R9: Writing the default value 0 to the self-lock byte leaves it writable. Once the byte holds a nonzero value, further writes are ignored until a reset returns it to 0.
- R10: Read data is registered. A read strobe presents the addressed word on the next clock and the data holds between reads. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous cold reset, clears every field |
| warm_rst | input | 1 | Synchronous warm reset, clears non-sticky fields |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_addr | input | 3 | Word address |
| sw_wdata | input | 32 | Write data |
| sw_be | input | 4 | Byte-lane write enables |
| sw_rdata | output | 32 | Registered read data |
| evt_set | input | 8 | Event pulses setting Status [7:0] |
| evt_set_l | input | 8 | Event pulses setting Status [23:16] |
| vol_upd_en | input | 8 | Per-bit hardware update enable for Volatile [7:0] |
| vol_upd_val | input | 8 | Hardware update values for Volatile [7:0] |
| vols_upd_en | input | 8 | Per-bit hardware update enable for Volatile [23:16] |
| vols_upd_val | input | 8 | Hardware update values for Volatile [23:16] |

## Verification
The bench builds the bank with its defaults: 32-bit data, 8 status bits per group, 8-bit volatile fields, 16-bit config and sticky fields and an 8-bit self-lock byte. Every field is therefore reachable through its own byte lanes. With these widths, a single word write can collide a clearing write with an event, or a software write with a hardware update, on chosen bits. The bench also drives the whole key chain, including setting both keys in one write, and warm and cold resets between field writes.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_KEY   = 3'd0,
        REG_CFG   = 3'd1,
        REG_STAT  = 3'd2,
        REG_VOL   = 3'd3,
        REG_STKY  = 3'd4,
        REG_SLOCK = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        FK_RW  = 2'd0,
        FK_W1C = 2'd1,
        FK_VOL = 2'd2
    } field_kind_e;

    localparam int HI_LSB = 16;

endpackage

// File: rtl/cfgbank_field.sv
module cfgbank_field
    import cfgbank_pkg::*;
#(
    parameter int          W       = 8,
    parameter field_kind_e KIND    = FK_RW,
    parameter bit          STICKY  = 1'b0,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         cold_rst,
    input  logic         warm_rst,
    input  logic [W-1:0] sw_wmask,
    input  logic [W-1:0] sw_wdata,
    input  logic         lock,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_en,
    input  logic [W-1:0] hw_val,
    output logic [W-1:0] q
);

    logic [W-1:0] sw_ok;
    logic [W-1:0] sw_val;
    logic [W-1:0] nxt;
    logic         rst_now;

    assign rst_now = cold_rst || (warm_rst && !STICKY);
    assign sw_ok   = sw_wmask & {W{!lock}};

    generate
        if (KIND == FK_W1C) begin : g_w1c
            assign sw_val = q & ~sw_wdata;
        end else begin : g_plain
            assign sw_val = sw_wdata;
        end
    endgenerate

    always_comb begin
        nxt = (q & ~sw_ok) | (sw_val & sw_ok);
        nxt = nxt | hw_set;
        nxt = (nxt & ~hw_en) | (hw_val & hw_en);
    end

    always_ff @(posedge clk) begin
        if (rst_now) begin
            q <= RST_VAL;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/cfgbank_lock.sv
module cfgbank_lock #(
    parameter int          SL_W   = 8,
    parameter logic [SL_W-1:0] SL_RST = '0
) (
    input  logic            master_q,
    input  logic            casc_q,
    input  logic [SL_W-1:0] slock_q,
    output logic            lk_casc,
    output logic            lk_cfg,
    output logic            lk_master,
    output logic            lk_slock
);

    assign lk_casc   = master_q;
    assign lk_master = master_q;
    assign lk_cfg    = casc_q;
    assign lk_slock  = (slock_q != SL_RST);

endmodule

// File: rtl/cfgbank.sv
module cfgbank
    import cfgbank_pkg::*;
#(
    parameter int NSTAT   = 8,
    parameter int VOL_W   = 8,
    parameter int CFG_W   = 16,
    parameter int STK_W   = 16,
    parameter int SL_W    = 8,
    parameter int DATA_W  = 32,
    parameter logic [CFG_W-1:0] CFG_RST = 16'h00A5
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  logic              sw_wr,
    input  logic              sw_rd,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic [DATA_W/8-1:0] sw_be,
    output logic [DATA_W-1:0] sw_rdata,
    input  logic [NSTAT-1:0]  evt_set,
    input  logic [NSTAT-1:0]  evt_set_l,
    input  logic [VOL_W-1:0]  vol_upd_en,
    input  logic [VOL_W-1:0]  vol_upd_val,
    input  logic [VOL_W-1:0]  vols_upd_en,
    input  logic [VOL_W-1:0]  vols_upd_val
);

    localparam int NBYTE = DATA_W / 8;
    localparam logic [SL_W-1:0] SL_RST = '0;

    logic [DATA_W-1:0] bitmask;
    logic sel_key, sel_cfg, sel_stat, sel_vol, sel_stky, sel_slock;

    logic              master_q, casc_q;
    logic [CFG_W-1:0]  cfg_l_q, cfg_p_q;
    logic [NSTAT-1:0]  stat_s_q, stat_l_q;
    logic [VOL_W-1:0]  vol_q, vols_q;
    logic [STK_W-1:0]  stky_q;
    logic [SL_W-1:0]   slock_q;
    logic lk_casc, lk_cfg, lk_master, lk_slock;

    logic [DATA_W-1:0] rd_word;

    genvar b;
    generate
        for (b = 0; b < NBYTE; b++) begin : g_lane
            assign bitmask[b*8 +: 8] = {8{sw_be[b]}};
        end
    endgenerate

    assign sel_key   = sw_wr && (sw_addr == REG_KEY);
    assign sel_cfg   = sw_wr && (sw_addr == REG_CFG);
    assign sel_stat  = sw_wr && (sw_addr == REG_STAT);
    assign sel_vol   = sw_wr && (sw_addr == REG_VOL);
    assign sel_stky  = sw_wr && (sw_addr == REG_STKY);
    assign sel_slock = sw_wr && (sw_addr == REG_SLOCK);

    cfgbank_lock #(.SL_W(SL_W), .SL_RST(SL_RST)) u_lock (
        .master_q (master_q),
        .casc_q   (casc_q),
        .slock_q  (slock_q),
        .lk_casc  (lk_casc),
        .lk_cfg   (lk_cfg),
        .lk_master(lk_master),
        .lk_slock (lk_slock)
    );

    cfgbank_field #(.W(1), .KIND(FK_RW), .STICKY(1'b0), .RST_VAL(1'b0)) u_key_m (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask(sel_key & bitmask[0]), .sw_wdata(sw_wdata[0]), .lock(1'b0),
        .hw_set(1'b0), .hw_en(1'b0), .hw_val(1'b0), .q(master_q)
    );

    cfgbank_field #(.W(1), .KIND(FK_RW), .STICKY(1'b0), .RST_VAL(1'b0)) u_key_c (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask(sel_key & bitmask[1]), .sw_wdata(sw_wdata[1]), .lock(lk_casc),
        .hw_set(1'b0), .hw_en(1'b0), .hw_val(1'b0), .q(casc_q)
    );

    cfgbank_field #(.W(CFG_W), .KIND(FK_RW), .STICKY(1'b0), .RST_VAL(CFG_RST)) u_cfg_l (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask({CFG_W{sel_cfg}} & bitmask[CFG_W-1:0]),
        .sw_wdata(sw_wdata[CFG_W-1:0]), .lock(lk_cfg),
        .hw_set('0), .hw_en('0), .hw_val('0), .q(cfg_l_q)
    );

    cfgbank_field #(.W(CFG_W), .KIND(FK_RW), .STICKY(1'b0), .RST_VAL('0)) u_cfg_p (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask({CFG_W{sel_cfg}} & bitmask[HI_LSB +: CFG_W]),
        .sw_wdata(sw_wdata[HI_LSB +: CFG_W]), .lock(1'b0),
        .hw_set('0), .hw_en('0), .hw_val('0), .q(cfg_p_q)
    );

    cfgbank_field #(.W(NSTAT), .KIND(FK_W1C), .STICKY(1'b1), .RST_VAL('0)) u_stat_s (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask({NSTAT{sel_stat}} & bitmask[NSTAT-1:0]),
        .sw_wdata(sw_wdata[NSTAT-1:0]), .lock(1'b0),
        .hw_set(evt_set), .hw_en('0), .hw_val('0), .q(stat_s_q)
    );

    cfgbank_field #(.W(NSTAT), .KIND(FK_W1C), .STICKY(1'b1), .RST_VAL('0)) u_stat_l (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask({NSTAT{sel_stat}} & bitmask[HI_LSB +: NSTAT]),
        .sw_wdata(sw_wdata[HI_LSB +: NSTAT]), .lock(lk_master),
        .hw_set(evt_set_l), .hw_en('0), .hw_val('0), .q(stat_l_q)
    );

    cfgbank_field #(.W(VOL_W), .KIND(FK_VOL), .STICKY(1'b0), .RST_VAL('0)) u_vol (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask({VOL_W{sel_vol}} & bitmask[VOL_W-1:0]),
        .sw_wdata(sw_wdata[VOL_W-1:0]), .lock(lk_master),
        .hw_set('0), .hw_en(vol_upd_en), .hw_val(vol_upd_val), .q(vol_q)
    );

    cfgbank_field #(.W(VOL_W), .KIND(FK_VOL), .STICKY(1'b1), .RST_VAL('0)) u_vols (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask({VOL_W{sel_vol}} & bitmask[HI_LSB +: VOL_W]),
        .sw_wdata(sw_wdata[HI_LSB +: VOL_W]), .lock(lk_master),
        .hw_set('0), .hw_en(vols_upd_en), .hw_val(vols_upd_val), .q(vols_q)
    );

    cfgbank_field #(.W(STK_W), .KIND(FK_RW), .STICKY(1'b1), .RST_VAL('0)) u_stky (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask({STK_W{sel_stky}} & bitmask[STK_W-1:0]),
        .sw_wdata(sw_wdata[STK_W-1:0]), .lock(1'b0),
        .hw_set('0), .hw_en('0), .hw_val('0), .q(stky_q)
    );

    cfgbank_field #(.W(SL_W), .KIND(FK_RW), .STICKY(1'b0), .RST_VAL(SL_RST)) u_slock (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wmask({SL_W{sel_slock}} & bitmask[SL_W-1:0]),
        .sw_wdata(sw_wdata[SL_W-1:0]), .lock(lk_slock),
        .hw_set('0), .hw_en('0), .hw_val('0), .q(slock_q)
    );

    always_comb begin
        rd_word = '0;
        case (sw_addr)
            REG_KEY: begin
                rd_word[0] = master_q;
                rd_word[1] = casc_q;
            end
            REG_CFG: begin
                rd_word[CFG_W-1:0]       = cfg_l_q;
                rd_word[HI_LSB +: CFG_W] = cfg_p_q;
            end
            REG_STAT: begin
                rd_word[NSTAT-1:0]       = stat_s_q;
                rd_word[HI_LSB +: NSTAT] = stat_l_q;
            end
            REG_VOL: begin
                rd_word[VOL_W-1:0]       = vol_q;
                rd_word[HI_LSB +: VOL_W] = vols_q;
            end
            REG_STKY:  rd_word[STK_W-1:0] = stky_q;
            REG_SLOCK: rd_word[SL_W-1:0]  = slock_q;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (cold_rst || warm_rst) begin
            sw_rdata <= '0;
        end else if (sw_rd) begin
            sw_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
    import cfgbank_pkg::*;
#(
    parameter int NSTAT  = 8,
    parameter int VOL_W  = 8,
    parameter int CFG_W  = 16,
    parameter int STK_W  = 16,
    parameter int SL_W   = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              cold_rst,
    input logic              warm_rst,
    input logic              sw_wr,
    input logic              sw_rd,
    input logic [ADDR_W-1:0] sw_addr,
    input logic [DATA_W-1:0] sw_rdata,
    input logic [NSTAT-1:0]  evt_set,
    input logic [VOL_W-1:0]  vol_upd_en,
    input logic [VOL_W-1:0]  vol_upd_val,
    input logic              casc_q,
    input logic [CFG_W-1:0]  cfg_l_q,
    input logic [NSTAT-1:0]  stat_s_q,
    input logic [VOL_W-1:0]  vol_q,
    input logic [STK_W-1:0]  stky_q,
    input logic [SL_W-1:0]   slock_q
);

    // R1: cold reset clears the sticky status and sticky word
    p_cold_clears_r1: assert property (@(posedge clk) disable iff (warm_rst)
        cold_rst |=> (stat_s_q == '0 && stky_q == '0));

    // R3: an event always leaves its bit set
    p_evt_sets_r3: assert property (@(posedge clk) disable iff (cold_rst)
        (|evt_set) |=> ((stat_s_q & $past(evt_set)) == $past(evt_set)));

    // R4: warm reset leaves the sticky word alone
    p_warm_keeps_r4: assert property (@(posedge clk) disable iff (cold_rst)
        (warm_rst && !(sw_wr && sw_addr == REG_STKY)) |=> $stable(stky_q));

    // R6: locked config field does not move
    p_cfg_locked_r6: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (casc_q && sw_wr && sw_addr == REG_CFG) |=> $stable(cfg_l_q));

    // R8: hardware update value lands on its bits
    p_vol_hw_r8: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (|vol_upd_en) |=> ((vol_q & $past(vol_upd_en)) == ($past(vol_upd_val) & $past(vol_upd_en))));

    // R9: nonzero self-lock byte ignores writes
    p_selflock_r9: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (slock_q != '0 && sw_wr && sw_addr == REG_SLOCK) |=> $stable(slock_q));

    // R10: unmapped reads return zero
    p_unmapped_r10: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (sw_rd && sw_addr > REG_SLOCK) |=> (sw_rdata == '0));

endmodule

bind cfgbank cfgbank_chk #(
    .NSTAT(NSTAT), .VOL_W(VOL_W), .CFG_W(CFG_W),
    .STK_W(STK_W), .SL_W(SL_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_addr(sw_addr), .sw_rdata(sw_rdata),
    .evt_set(evt_set), .vol_upd_en(vol_upd_en), .vol_upd_val(vol_upd_val),
    .casc_q(casc_q), .cfg_l_q(cfg_l_q), .stat_s_q(stat_s_q),
    .vol_q(vol_q), .stky_q(stky_q), .slock_q(slock_q)
);

// File: tb/cfgbank_tb.sv
module cfgbank_tb;

    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        sw_wr = 1'b0;
    logic        sw_rd = 1'b0;
    logic [2:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [3:0]  sw_be = '0;
    logic [31:0] sw_rdata;
    logic [7:0]  evt_set = '0, evt_set_l = '0;
    logic [7:0]  vol_upd_en = '0, vol_upd_val = '0;
    logic [7:0]  vols_upd_en = '0, vols_upd_val = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cfgbank u_dut (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_be(sw_be), .sw_rdata(sw_rdata),
        .evt_set(evt_set), .evt_set_l(evt_set_l),
        .vol_upd_en(vol_upd_en), .vol_upd_val(vol_upd_val),
        .vols_upd_en(vols_upd_en), .vols_upd_val(vols_upd_val)
    );

    localparam logic [2:0] A_KEY = 3'd0, A_CFG = 3'd1, A_STAT = 3'd2,
                           A_VOL = 3'd3, A_STKY = 3'd4, A_SLOCK = 3'd5;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic [7:0] es, input logic [7:0] esl,
                       input logic [7:0] ven, input logic [7:0] vval,
                       input logic [7:0] vsen, input logic [7:0] vsval);
        @(negedge clk);
        sw_wr = wr; sw_addr = a; sw_wdata = d; sw_be = be;
        evt_set = es; evt_set_l = esl;
        vol_upd_en = ven; vol_upd_val = vval;
        vols_upd_en = vsen; vols_upd_val = vsval;
        @(negedge clk);
        sw_wr = 1'b0; sw_be = '0; evt_set = '0; evt_set_l = '0;
        vol_upd_en = '0; vol_upd_val = '0; vols_upd_en = '0; vols_upd_val = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        cyc(1'b1, a, d, be, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        sw_rd = 1'b1; sw_addr = a;
        @(negedge clk);
        sw_rd = 1'b0;
        v = sw_rdata;
    endtask

    task automatic do_cold();
        @(negedge clk); cold_rst = 1'b1;
        @(negedge clk); cold_rst = 1'b0;
    endtask

    task automatic do_warm();
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_cold();
        rd(A_KEY, v);   chk("R1 keys", v, 32'h0);
        rd(A_CFG, v);   chk("R1 config", v, 32'h000000A5);
        rd(A_STAT, v);  chk("R1 status", v, 32'h0);
        rd(A_VOL, v);   chk("R1 volatile", v, 32'h0);
        rd(A_STKY, v);  chk("R1 sticky", v, 32'h0);
        rd(A_SLOCK, v); chk("R1 selflock", v, 32'h0);
    endtask

    task automatic t_strobes();
        logic [31:0] v;
        do_cold();
        wr(A_STKY, 32'hFFFFABCD, 4'b0001);
        rd(A_STKY, v); chk("R2 lane0 only", v, 32'h000000CD);
        wr(A_STKY, 32'h00001200, 4'b0010);
        rd(A_STKY, v); chk("R2 lane1 only", v, 32'h000012CD);
        wr(A_CFG, 32'hAAAABBBB, 4'b1100);
        rd(A_CFG, v); chk("R2 upper lanes", v, 32'hAAAA00A5);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        do_cold();
        cyc(1'b0, A_STAT, 32'h0, 4'h0, 8'h0F, 8'h03, 8'h0, 8'h0, 8'h0, 8'h0);
        rd(A_STAT, v); chk("R3 events set", v, 32'h0003000F);
        wr(A_STAT, 32'h00010005, 4'hF);
        rd(A_STAT, v); chk("R3 write one clears", v, 32'h0002000A);
        wr(A_STAT, 32'h00000000, 4'hF);
        rd(A_STAT, v); chk("R3 write zero no effect", v, 32'h0002000A);
        cyc(1'b1, A_STAT, 32'h00000002, 4'hF, 8'h02, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
        rd(A_STAT, v); chk("R3 set wins over clear", v, 32'h0002000A);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        do_cold();
        wr(A_STKY, 32'h0000BEEF, 4'hF);
        wr(A_CFG, 32'h77771111, 4'hF);
        wr(A_KEY, 32'h1, 4'hF);
        wr(A_SLOCK, 32'h44, 4'hF);
        cyc(1'b0, A_STAT, 32'h0, 4'h0, 8'h81, 8'h40, 8'h0F, 8'h09, 8'hF0, 8'h60);
        do_warm();
        rd(A_STKY, v);  chk("R4 warm keeps sticky word", v, 32'h0000BEEF);
        rd(A_STAT, v);  chk("R4 warm keeps status", v, 32'h00400081);
        rd(A_VOL, v);   chk("R4 warm keeps only sticky volatile", v, 32'h00600000);
        rd(A_CFG, v);   chk("R4 warm resets config", v, 32'h000000A5);
        rd(A_KEY, v);   chk("R4 warm resets keys", v, 32'h0);
        rd(A_SLOCK, v); chk("R4 warm resets selflock", v, 32'h0);
        do_cold();
        rd(A_STKY, v);  chk("R4 cold clears sticky word", v, 32'h0);
        rd(A_STAT, v);  chk("R4 cold clears status", v, 32'h0);
        rd(A_VOL, v);   chk("R4 cold clears volatile", v, 32'h0);
    endtask

    task automatic t_master_lock();
        logic [31:0] v;
        do_cold();
        wr(A_VOL, 32'h00000033, 4'hF);
        cyc(1'b0, A_STAT, 32'h0, 4'h0, 8'h0, 8'h01, 8'h0, 8'h0, 8'h0, 8'h0);
        wr(A_KEY, 32'h1, 4'hF);
        wr(A_KEY, 32'h3, 4'hF);
        rd(A_KEY, v);  chk("R5 cascaded key frozen", v, 32'h1);
        wr(A_VOL, 32'h00FF00FF, 4'hF);
        rd(A_VOL, v);  chk("R5 volatile writes ignored", v, 32'h00000033);
        wr(A_STAT, 32'h00010000, 4'hF);
        rd(A_STAT, v); chk("R5 locked clear ignored", v, 32'h00010000);
        cyc(1'b0, A_VOL, 32'h0, 4'h0, 8'h0, 8'h0, 8'h0F, 8'h05, 8'h03, 8'h02);
        rd(A_VOL, v);  chk("R8 hw update while locked", v, 32'h00020035);
        wr(A_KEY, 32'h0, 4'hF);
        rd(A_KEY, v);  chk("R5 upstream key writable", v, 32'h0);
    endtask

    task automatic t_cascade();
        logic [31:0] v;
        do_cold();
        wr(A_CFG, 32'h00005A5A, 4'hF);
        rd(A_CFG, v); chk("R6 unlocked config write", v, 32'h00005A5A);
        wr(A_KEY, 32'h2, 4'hF);
        wr(A_CFG, 32'hFFFF1111, 4'hF);
        rd(A_CFG, v); chk("R6 cascaded lock holds low field", v, 32'hFFFF5A5A);
        wr(A_KEY, 32'h0, 4'hF);
        wr(A_CFG, 32'h00001111, 4'hF);
        rd(A_CFG, v); chk("R6 unlock restores writes", v, 32'h00001111);
        do_cold();
        wr(A_KEY, 32'h3, 4'hF);
        rd(A_KEY, v); chk("R7 both keys set in one write", v, 32'h3);
        wr(A_CFG, 32'h1234FFFF, 4'hF);
        rd(A_CFG, v); chk("R7 chain locks config", v, 32'h123400A5);
    endtask

    task automatic t_volatile();
        logic [31:0] v;
        do_cold();
        cyc(1'b1, A_VOL, 32'h00AA00FF, 4'hF, 8'h0, 8'h0, 8'h01, 8'h00, 8'h80, 8'h00);
        rd(A_VOL, v); chk("R8 hw beats sw same cycle", v, 32'h002A00FE);
    endtask

    task automatic t_selflock();
        logic [31:0] v;
        do_cold();
        wr(A_SLOCK, 32'h0, 4'hF);
        wr(A_SLOCK, 32'h5A, 4'hF);
        rd(A_SLOCK, v); chk("R9 default write keeps unlocked", v, 32'h5A);
        wr(A_SLOCK, 32'h33, 4'hF);
        rd(A_SLOCK, v); chk("R9 locked after nonzero", v, 32'h5A);
        do_warm();
        wr(A_SLOCK, 32'h33, 4'hF);
        rd(A_SLOCK, v); chk("R9 reset releases lock", v, 32'h33);
    endtask

    task automatic t_read();
        logic [31:0] v;
        do_cold();
        wr(A_STKY, 32'h00001357, 4'hF);
        rd(A_STKY, v); chk("R10 read", v, 32'h00001357);
        wr(A_STKY, 32'h00002468, 4'hF);
        @(negedge clk);
        chk("R10 data holds without strobe", sw_rdata, 32'h00001357);
        rd(3'd6, v); chk("R10 address 6 zero", v, 32'h0);
        rd(3'd7, v); chk("R10 address 7 zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cold_rst = 1'b0;
        t_reset();
        t_strobes();
        t_w1c();
        t_sticky();
        t_master_lock();
        t_cascade();
        t_volatile();
        t_selflock();
        t_read();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule